// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side command decoder of a serial flash device. It watches a four-wire serial link (clock, active-low select, data in, data out) plus an active-low pause pin. It oversamples all of them on a fast system clock instead of clocking on the serial clock. Both idle polarities of the serial clock are handled: clock-low-at-idle (mode 0) and clock-high-at-idle (mode 3). Input bits are taken on serial-clock rising edges, and output bits change on falling edges. Every field travels most significant bit first.

From the first byte after select falls, the block decodes the command. It then collects a 24-bit address and any data bytes, and turns them into single-cycle requests toward the array and the status logic. Requests that change state are released only when select rises exactly on a byte boundary after the right number of bytes. While the array reports busy, every command except the status read is refused. The pause pin freezes the link and floats the data output. Output data for reads comes from the array through a plain address/data pair. The array must present `rd_data` for `rd_addr` within one serial byte time.

Program data leaves the block as a byte stream on `pp_valid`/`pp_data`/`pp_addr`. That stream has no ready signal, because the serial host cannot be stalled. The consumer must accept one byte on every cycle `pp_valid` is high. It must hold the bytes until `pp_commit` confirms them or `pp_cancel` discards them.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no request pulse is issued, and `miso_oe` is 0 whenever select (`cs_n`) is high.
- R2: Opcode 06h raises `wr_en_req` and opcode 04h raises `wr_dis_req`. Each is released only when select rises after exactly 8 serial clocks. One extra clock cancels it.
- R3: Opcode 05h drives `status_byte` on `miso`, MSB first, repeated for as long as select stays low. This works in mode 0 and mode 3, and also while `busy` is 1.
- R4: Opcode 15h returns the bytes 7Fh, 7Fh, 5Eh, 01h, then starts again at 7Fh.
- R5: Opcode 03h takes a 3-byte address, whose low 16 bits are used, and returns array bytes from ascending addresses until select rises.
- R6: During a read the address stops at FFFFh and does not wrap to 0000h.
- R7: Opcode 02h takes a 3-byte address. It then emits each data byte on `pp_valid`. The address of each byte increments in its low 7 bits and wraps within the same 128-byte page. If select rises on a byte boundary after at least one data byte, `pp_commit` pulses. Otherwise `pp_cancel` pulses.
- R8: Opcode D8h (sector erase, address on `cmd_addr`) must end after exactly 4 bytes, opcode C7h (chip erase) after exactly 1 byte, and opcode 01h (status write, data on `stat_wr_data`) after exactly 2 bytes. Any other length issues nothing.
- R9: While `busy` is 1 when the opcode completes, any opcode other than 05h is refused. No data is driven and no request or program byte is issued.
- R10: An opcode outside the list is ignored, together with everything that follows it, until select rises.
- R11: A pause starts or ends only while the serial clock is low. During a pause `miso_oe` is 0 and serial clock edges and input data are ignored. The transfer then resumes where it stopped.
- R12: If select rises during a pause, the command is dropped without any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | High when `miso` is driven, low models high impedance |
| busy | input | 1 | Array or status cycle in progress |
| status_byte | input | 8 | Status value returned by opcode 05h |
| rd_addr | output | ADDR_W | Read address toward the array |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_en_req | output | 1 | Pulse: set write enable |
| wr_dis_req | output | 1 | Pulse: clear write enable |
| stat_wr_req | output | 1 | Pulse: write status register |
| stat_wr_data | output | 8 | Value for the status write |
| pp_valid | output | 1 | Program byte valid (no back-pressure) |
| pp_data | output | 8 | Program byte |
| pp_addr | output | ADDR_W | Address of the program byte |
| pp_commit | output | 1 | Pulse: program the collected bytes |
| pp_cancel | output | 1 | Pulse: discard the collected bytes |
| sect_erase_req | output | 1 | Pulse: erase the sector holding `cmd_addr` |
| chip_erase_req | output | 1 | Pulse: erase the whole array |
| cmd_addr | output | ADDR_W | Address taken from the command |

## Verification
Some properties are checked on every cycle. At most one request pulse fires at a time, and every request appears only while select is high. Program bytes never leave the page given by the command address. The read address never moves backwards within one read. The pause state changes only while the serial clock is low. The bench scenarios are needed for the rest: opcode decoding, exact byte-count rules, the data returned on `miso` in both clock polarities, refusal while busy, and the resumption of a paused transfer at the right bit.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_RDID = 8'h15;

  typedef enum logic [2:0] {
    PH_OPC,   // collecting the opcode
    PH_ADDR,  // collecting address bytes
    PH_DIN,   // collecting data bytes
    PH_DOUT,  // returning bytes on miso
    PH_WAIT,  // waiting for select to rise
    PH_SKIP   // refused or unknown, ignore until deselect
  } phase_t;

  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0, 2'd1: return 8'h7F;
      2'd2:       return 8'h5E;
      default:    return 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/fc_sync.sv
`timescale 1ns/1ps
module fc_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{INIT}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/fc_hold.sv
`timescale 1ns/1ps
module fc_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic hold_s,
  output logic hold_active
);
  // pause state follows the pin only while the serial clock is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_active <= 1'b0;
    else if (!sck_s) hold_active <= ~hold_s;
  end

  AST_HOLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_active) |-> !$past(sck_s)); // R11
endmodule

// File: rtl/fc_tx.sv
`timescale 1ns/1ps
module fc_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shift_en,
  input  logic [7:0] load_byte,
  output logic       take,
  output logic       tx_bit,
  output logic       live
);
  logic [7:0] sh;
  logic [2:0] cnt;

  assign take   = shift_en && (cnt == 3'd0);
  assign tx_bit = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; live <= 1'b0;
    end else if (clear) begin
      cnt <= '0; live <= 1'b0;
    end else if (shift_en) begin
      sh   <= take ? load_byte : {sh[6:0], 1'b0};
      cnt  <= cnt + 3'd1;
      live <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              busy,
  input  logic [7:0]        status_byte,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en_req,
  output logic              wr_dis_req,
  output logic              stat_wr_req,
  output logic [7:0]        stat_wr_data,
  output logic              pp_valid,
  output logic [7:0]        pp_data,
  output logic [ADDR_W-1:0] pp_addr,
  output logic              pp_commit,
  output logic              pp_cancel,
  output logic              sect_erase_req,
  output logic              chip_erase_req,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam logic [2:0] CNT_MAX = 3'd7;
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic sck_s, cs_s, hold_s, mosi_s, sck_d, cs_d, hold_active;
  logic sel, sck_rise, sck_fall, cs_rise, rise_ev, fall_ev;

  fc_sync #(.N(4), .STAGES(SYNC_STAGES), .INIT(4'b1110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, cs_n, hold_n, mosi}),
    .q({sck_s, cs_s, hold_s, mosi_s}));

  fc_hold u_hold (.clk(clk), .rst_n(rst_n), .sck_s(sck_s), .hold_s(hold_s),
                  .hold_active(hold_active));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin sck_d <= 1'b1; cs_d <= 1'b1; end
    else        begin sck_d <= sck_s; cs_d <= cs_s; end
  end

  assign sel      = ~cs_s;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign rise_ev  = sck_rise & sel & ~hold_active;
  assign fall_ev  = sck_fall & sel & ~hold_active;

  phase_t            phase;
  logic [7:0]        cmd;
  logic [6:0]        rx_sh;
  logic [2:0]        bit_cnt, byte_cnt;
  logic [ADDR_W-1:0] addr_sh, ptr;
  logic [1:0]        id_idx;
  logic [7:0]        rx_byte, tx_load;
  logic [ADDR_W-1:0] addr_full;
  logic              open_cmd, align_ok, pp_ok, tx_take, tx_bit, tx_live;

  assign rx_byte   = {rx_sh, mosi_s};
  assign addr_full = {addr_sh[ADDR_W-9:0], rx_byte};
  assign open_cmd  = (phase != PH_OPC) && (phase != PH_SKIP);
  assign align_ok  = open_cmd && (bit_cnt == 3'd0) && !hold_active;
  assign pp_ok     = align_ok && (byte_cnt >= 3'd5);

  always_comb begin
    case (cmd)
      OP_READ: tx_load = rd_data;
      OP_RDSR: tx_load = status_byte;
      default: tx_load = id_byte(id_idx);
    endcase
  end

  fc_tx u_tx (.clk(clk), .rst_n(rst_n), .clear(~sel),
              .shift_en(fall_ev && phase == PH_DOUT), .load_byte(tx_load),
              .take(tx_take), .tx_bit(tx_bit), .live(tx_live));

  assign miso    = tx_bit;
  assign miso_oe = tx_live & sel & ~hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OPC; cmd <= '0; rx_sh <= '0; bit_cnt <= '0; byte_cnt <= '0;
      addr_sh <= '0; ptr <= '0; id_idx <= '0; rd_addr <= '0; cmd_addr <= '0;
      wr_en_req <= 1'b0; wr_dis_req <= 1'b0; stat_wr_req <= 1'b0;
      stat_wr_data <= '0; pp_valid <= 1'b0; pp_data <= '0; pp_addr <= '0;
      pp_commit <= 1'b0; pp_cancel <= 1'b0;
      sect_erase_req <= 1'b0; chip_erase_req <= 1'b0;
    end else begin
      wr_en_req <= 1'b0; wr_dis_req <= 1'b0; stat_wr_req <= 1'b0;
      pp_valid <= 1'b0; pp_commit <= 1'b0; pp_cancel <= 1'b0;
      sect_erase_req <= 1'b0; chip_erase_req <= 1'b0;

      if (cs_rise && align_ok) begin
        case (cmd)
          OP_WREN: wr_en_req      <= (byte_cnt == 3'd1);
          OP_WRDI: wr_dis_req     <= (byte_cnt == 3'd1);
          OP_BE:   chip_erase_req <= (byte_cnt == 3'd1);
          OP_WRSR: stat_wr_req    <= (byte_cnt == 3'd2);
          OP_SE:   sect_erase_req <= (byte_cnt == 3'd4);
          OP_PP:   pp_commit      <= pp_ok;
          default: ;
        endcase
      end
      if (cs_rise && open_cmd && cmd == OP_PP && !pp_ok) pp_cancel <= 1'b1;

      if (!sel) begin
        phase <= PH_OPC; bit_cnt <= '0; byte_cnt <= '0;
      end else if (rise_ev) begin
        rx_sh   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_cnt <= (byte_cnt == CNT_MAX) ? byte_cnt : byte_cnt + 3'd1;
          case (phase)
            PH_OPC: begin
              cmd    <= rx_byte;
              id_idx <= '0;
              if (busy && rx_byte != OP_RDSR) phase <= PH_SKIP;
              else begin
                case (rx_byte)
                  OP_WREN, OP_WRDI, OP_BE:  phase <= PH_WAIT;
                  OP_RDSR, OP_RDID:         phase <= PH_DOUT;
                  OP_WRSR:                  phase <= PH_DIN;
                  OP_READ, OP_PP, OP_SE:    phase <= PH_ADDR;
                  default:                  phase <= PH_SKIP;
                endcase
              end
            end
            PH_ADDR: begin
              addr_sh <= addr_full;
              if (byte_cnt == 3'd3) begin
                cmd_addr <= addr_full;
                ptr      <= addr_full;
                if (cmd == OP_READ) begin
                  rd_addr <= addr_full; phase <= PH_DOUT;
                end else if (cmd == OP_PP) phase <= PH_DIN;
                else                       phase <= PH_WAIT;
              end
            end
            PH_DIN: begin
              if (cmd == OP_WRSR) begin
                stat_wr_data <= rx_byte; phase <= PH_WAIT;
              end else begin
                pp_valid <= 1'b1; pp_data <= rx_byte; pp_addr <= ptr;
                ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
              end
            end
            default: ;
          endcase
        end
      end else if (tx_take) begin
        if (cmd == OP_READ && rd_addr != ADDR_TOP) rd_addr <= rd_addr + 1'b1;
        if (cmd == OP_RDID) id_idx <= id_idx + 2'd1;
      end
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_req, wr_dis_req, stat_wr_req, sect_erase_req,
              chip_erase_req, pp_commit, pp_cancel})); // R8
  AST_REQ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_req | wr_dis_req | stat_wr_req | sect_erase_req | chip_erase_req
     | pp_commit) |-> cs_s); // R2
  AST_PP_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    pp_valid |-> pp_addr[ADDR_W-1:PAGE_W] == cmd_addr[ADDR_W-1:PAGE_W]); // R7
  AST_RD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DOUT && $past(phase) == PH_DOUT && cmd == OP_READ)
      |-> rd_addr >= $past(rd_addr)); // R6
endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sck, cs_n, hold_n, mosi, busy, mode3;
  logic [7:0] status_byte, rd_data, stat_wr_data, pp_data;
  logic [15:0] rd_addr, pp_addr, cmd_addr;
  logic miso, miso_oe, wr_en_req, wr_dis_req, stat_wr_req, pp_valid;
  logic pp_commit, pp_cancel, sect_erase_req, chip_erase_req;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .busy(busy),
    .status_byte(status_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en_req(wr_en_req), .wr_dis_req(wr_dis_req),
    .stat_wr_req(stat_wr_req), .stat_wr_data(stat_wr_data),
    .pp_valid(pp_valid), .pp_data(pp_data), .pp_addr(pp_addr),
    .pp_commit(pp_commit), .pp_cancel(pp_cancel),
    .sect_erase_req(sect_erase_req), .chip_erase_req(chip_erase_req),
    .cmd_addr(cmd_addr));

  function automatic logic [7:0] arr(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign rd_data = arr(rd_addr);

  int n_chk = 0, n_fail = 0;
  int n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_se = 0, n_be = 0;
  int n_commit = 0, n_cancel = 0, n_pp = 0;
  logic [7:0] pp_d [256];
  logic [15:0] pp_a [256];
  logic [7:0] last_stat = '0;
  logic [15:0] last_eaddr = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (wr_en_req) n_wren++;
    if (wr_dis_req) n_wrdi++;
    if (stat_wr_req) begin n_wrsr++; last_stat = stat_wr_data; end
    if (sect_erase_req) begin n_se++; last_eaddr = cmd_addr; end
    if (chip_erase_req) n_be++;
    if (pp_commit) n_commit++;
    if (pp_cancel) n_cancel++;
    if (pp_valid) begin
      pp_d[n_pp % 256] = pp_data; pp_a[n_pp % 256] = pp_addr; n_pp++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on();
    cs_n = 1'b0; waitn(H);
  endtask

  task automatic bit_x(input logic b, output logic o);
    sck = 1'b0; mosi = b; waitn(H);
    o = miso; sck = 1'b1; waitn(H);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic o;
      bit_x(tx[i], o);
      rx[i] = o;
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    byte_x(b, d);
  endtask

  task automatic cs_off();
    if (!mode3) begin sck = 1'b0; waitn(H); end
    cs_n = 1'b1; waitn(3 * H);
  endtask

  task automatic t_reset();
    chk(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
    chk(n_wren + n_wrdi + n_wrsr + n_se + n_be + n_commit + n_cancel + n_pp == 0,
        "R1 no request after reset", n_wren + n_pp, 0);
  endtask

  task automatic t_wren();
    int b0, b1;
    logic o;
    b0 = n_wren; b1 = n_wrdi;
    cs_on(); send(8'h06); cs_off();
    chk(n_wren == b0 + 1, "R2 write enable pulse", n_wren - b0, 1);
    cs_on(); send(8'h04); cs_off();
    chk(n_wrdi == b1 + 1, "R2 write disable pulse", n_wrdi - b1, 1);
    cs_on(); send(8'h06); bit_x(1'b0, o); cs_off();
    chk(n_wren == b0 + 1, "R2 nine clocks rejected", n_wren - b0, 1);
  endtask

  task automatic t_rdsr();
    logic [7:0] r;
    status_byte = 8'hA6; busy = 1'b1;
    cs_on(); send(8'h05);
    byte_x(8'h00, r);
    chk(r == 8'hA6, "R3 status first byte", r, 8'hA6);
    chk(miso_oe == 1'b1, "R3 output driven", miso_oe, 1);
    byte_x(8'h00, r);
    chk(r == 8'hA6, "R3 status repeated", r, 8'hA6);
    cs_off();
    chk(miso_oe == 1'b0, "R1 oe off when deselected", miso_oe, 0);
    busy = 1'b0;
    mode3 = 1'b1; sck = 1'b1; waitn(H); status_byte = 8'h3D;
    cs_on(); send(8'h05); byte_x(8'h00, r); cs_off();
    chk(r == 8'h3D, "R3 status in mode 3", r, 8'h3D);
    mode3 = 1'b0; sck = 1'b0; waitn(H);
  endtask

  task automatic t_rdid();
    logic [7:0] r;
    logic [7:0] exp [5] = '{8'h7F, 8'h7F, 8'h5E, 8'h01, 8'h7F};
    cs_on(); send(8'h15);
    for (int k = 0; k < 5; k++) begin
      byte_x(8'h00, r);
      chk(r == exp[k], "R4 identification byte", r, exp[k]);
    end
    cs_off();
  endtask

  task automatic t_read();
    logic [7:0] r;
    cs_on(); send(8'h03); send(8'h01); send(8'h12); send(8'h34);
    for (int k = 0; k < 3; k++) begin
      byte_x(8'h00, r);
      chk(r == arr(16'h1234 + 16'(k)), "R5 read stream", r, arr(16'h1234 + 16'(k)));
    end
    cs_off();
    cs_on(); send(8'h03); send(8'h00); send(8'hFF); send(8'hFE);
    byte_x(8'h00, r);
    chk(r == arr(16'hFFFE), "R6 read below top", r, arr(16'hFFFE));
    byte_x(8'h00, r);
    chk(r == arr(16'hFFFF), "R6 read top", r, arr(16'hFFFF));
    byte_x(8'h00, r);
    chk(r == arr(16'hFFFF), "R6 no wrap past top", r, arr(16'hFFFF));
    cs_off();
  endtask

  task automatic t_pp();
    int p0, c0, x0;
    logic o;
    p0 = n_pp; c0 = n_commit; x0 = n_cancel;
    cs_on(); send(8'h02); send(8'h00); send(8'h03); send(8'h7E);
    send(8'h11); send(8'h22); send(8'h33); cs_off();
    chk(n_pp == p0 + 3, "R7 program byte count", n_pp - p0, 3);
    chk(pp_a[(p0 + 2) % 256] == 16'h0300, "R7 page wrap address",
        pp_a[(p0 + 2) % 256], 16'h0300);
    chk(pp_d[(p0 + 1) % 256] == 8'h22 && pp_a[(p0 + 1) % 256] == 16'h037F,
        "R7 second byte", pp_d[(p0 + 1) % 256], 8'h22);
    chk(n_commit == c0 + 1 && n_cancel == x0, "R7 aligned commit", n_commit - c0, 1);
    cs_on(); send(8'h02); send(8'h00); send(8'h01); send(8'h00); send(8'hAA);
    bit_x(1'b1, o); bit_x(1'b0, o); bit_x(1'b1, o); cs_off();
    chk(n_commit == c0 + 1 && n_cancel == x0 + 1, "R7 misaligned cancel",
        n_cancel - x0, 1);
  endtask

  task automatic t_erase();
    int s0, b0, w0;
    s0 = n_se; b0 = n_be; w0 = n_wrsr;
    cs_on(); send(8'hD8); send(8'h00); send(8'h81); send(8'h23); cs_off();
    chk(n_se == s0 + 1 && last_eaddr == 16'h8123, "R8 sector erase",
        last_eaddr, 16'h8123);
    cs_on(); send(8'hD8); send(8'h00); send(8'h81); send(8'h23); send(8'h00); cs_off();
    chk(n_se == s0 + 1, "R8 sector erase too long", n_se - s0, 1);
    cs_on(); send(8'hC7); cs_off();
    chk(n_be == b0 + 1, "R8 chip erase", n_be - b0, 1);
    cs_on(); send(8'h01); send(8'h8C); cs_off();
    chk(n_wrsr == w0 + 1 && last_stat == 8'h8C, "R8 status write", last_stat, 8'h8C);
    cs_on(); send(8'h01); cs_off();
    chk(n_wrsr == w0 + 1, "R8 status write without data", n_wrsr - w0, 1);
  endtask

  task automatic t_busy();
    int p0, c0, x0, e0;
    logic [7:0] r;
    busy = 1'b1;
    p0 = n_pp; c0 = n_commit; x0 = n_cancel; e0 = n_wren;
    cs_on(); send(8'h03); send(8'h00); send(8'h00); send(8'h10);
    byte_x(8'h00, r);
    chk(miso_oe == 1'b0, "R9 read refused while busy", miso_oe, 0);
    cs_off();
    cs_on(); send(8'h02); send(8'h00); send(8'h00); send(8'h10); send(8'h55); cs_off();
    chk(n_pp == p0 && n_commit == c0 && n_cancel == x0, "R9 program refused",
        n_pp - p0, 0);
    cs_on(); send(8'h06); cs_off();
    chk(n_wren == e0, "R9 write enable refused", n_wren - e0, 0);
    busy = 1'b0;
  endtask

  task automatic t_unknown();
    int e0;
    logic [7:0] r;
    e0 = n_wren;
    cs_on(); send(8'hAB); send(8'h06); byte_x(8'h05, r);
    chk(miso_oe == 1'b0, "R10 unknown opcode drives nothing", miso_oe, 0);
    cs_off();
    chk(n_wren == e0, "R10 trailing bytes ignored", n_wren - e0, 0);
    cs_on(); send(8'h06); cs_off();
    chk(n_wren == e0 + 1, "R10 next command accepted", n_wren - e0, 1);
  endtask

  task automatic t_hold_read();
    logic [7:0] r;
    logic o;
    status_byte = 8'h5A;
    cs_on(); send(8'h05);
    for (int i = 7; i >= 4; i--) begin bit_x(1'b0, o); r[i] = o; end
    sck = 1'b0; waitn(H);
    hold_n = 1'b0; waitn(H);
    chk(miso_oe == 1'b0, "R11 output floats in pause", miso_oe, 0);
    repeat (3) begin sck = 1'b1; mosi = 1'b1; waitn(H); sck = 1'b0; waitn(H); end
    hold_n = 1'b1; waitn(H);
    chk(miso_oe == 1'b1, "R11 output back after pause", miso_oe, 1);
    for (int i = 3; i >= 0; i--) begin bit_x(1'b0, o); r[i] = o; end
    cs_off();
    chk(r == 8'h5A, "R11 read resumes at paused bit", r, 8'h5A);
  endtask

  task automatic t_hold_write();
    int w0;
    logic o;
    w0 = n_wrsr;
    cs_on(); send(8'h01);
    for (int i = 7; i >= 4; i--) bit_x(8'hC3 >> i, o);
    sck = 1'b0; waitn(H);
    hold_n = 1'b0; waitn(H);
    repeat (4) begin mosi = ~mosi; sck = 1'b1; waitn(H); sck = 1'b0; waitn(H); end
    hold_n = 1'b1; waitn(H);
    for (int i = 3; i >= 0; i--) bit_x(8'hC3 >> i, o);
    cs_off();
    chk(n_wrsr == w0 + 1 && last_stat == 8'hC3, "R11 input ignored in pause",
        last_stat, 8'hC3);
  endtask

  task automatic t_hold_cs();
    int e0;
    e0 = n_wren;
    cs_on(); send(8'h06);
    sck = 1'b0; waitn(H);
    hold_n = 1'b0; waitn(H);
    cs_n = 1'b1; waitn(3 * H);
    hold_n = 1'b1; waitn(H);
    chk(n_wren == e0, "R12 deselect in pause drops command", n_wren - e0, 0);
    cs_on(); send(8'h06); cs_off();
    chk(n_wren == e0 + 1, "R12 fresh command after reset", n_wren - e0, 1);
  endtask

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; hold_n = 1'b1; mosi = 1'b0;
    busy = 1'b0; mode3 = 1'b0; status_byte = 8'h00;
    waitn(5); rst_n = 1'b1; waitn(5);
    t_reset();
    t_wren();
    t_rdsr();
    t_rdid();
    t_read();
    t_pp();
    t_erase();
    t_busy();
    t_unknown();
    t_hold_read();
    t_hold_write();
    t_hold_cs();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule